// File: doc/BRIEF.md
# SPI Short Command Transmitter

This block sends a short write-only command of one to four bytes over SPI as one frame. No FIFO is involved. Software places the command right-aligned in a 32-bit word and gives the byte count minus one in a 2-bit field. It then pulses a command-start input that is separate from any ordinary transmit enable. The block asserts chip select, clocks the bits out on MOSI and returns chip select to its idle level. In the cycle after that it raises a one-cycle frame-done pulse, which is the only completion event of a command frame.

The block has no receive path, so it suits transfers that only write. Clock polarity, clock phase, bit order, chip-select polarity and the SCLK half-period are per-frame settings. They are captured together with the command word and the count when a frame starts, so a frame runs on the values present at its start.

Top module: `spi_cmd_tx`

## Requirements
- R1: After reset, and whenever no frame is running, `cmd_busy` and `frame_done` are 0, `spi_cs` sits at its inactive level (the inverse of `cs_high`), and `spi_sclk` equals `clk_pol`.
- R2: `cmd_len_m1` holds the byte count minus one (0 means 1 byte, 3 means 4 bytes). A frame carries exactly 8·(`cmd_len_m1`+1) SCLK cycles. Bits of `cmd_word` above that count are never sent.
- R3: With `send_lsb_first`=0 the frame sends bits 8n−1 down to 0 of the right-aligned word, so the most significant used byte goes first. In a 4-byte command made of two 16-bit units, the upper halfword goes out before the lower one.
- R4: With `send_lsb_first`=1 the frame sends bits 0 up to 8n−1, so byte 0 goes first with its least significant bit first.
- R5: The SCLK idle level is `clk_pol`. With `clk_pha`=0 each bit is valid at the leading (first) edge of its SCLK cycle. With `clk_pha`=1 it is valid at the trailing edge.
- R6: Chip select is at its active level (`spi_cs` = `cs_high`) for the whole frame and does not change during it.
- R7: The cycle `frame_done` is high is the only cycle in which `cmd_busy` falls. That cycle follows the clock edge that lies (16n+1)·(`half_div`+1) cycles after the edge that accepted `cmd_go`.
- R8: A `cmd_go` pulse while a frame is running is ignored. The running frame's bits and length do not change.
- R9: The command word, count and all mode inputs are captured when a frame starts. Changing them during the frame has no effect on that frame.
- R10: During a frame MOSI changes only in a cycle where SCLK also changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_word | input | 32 | Right-aligned command bytes |
| cmd_len_m1 | input | 2 | Byte count minus one |
| send_lsb_first | input | 1 | 1: LSB-first stream, 0: MSB-first stream |
| clk_pol | input | 1 | SCLK idle level |
| clk_pha | input | 1 | 0: bit valid at leading edge, 1: at trailing edge |
| cs_high | input | 1 | Active level of chip select |
| half_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| cmd_go | input | 1 | Start a command frame when idle |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs | output | 1 | Chip select |
| cmd_busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest situations to reach are the two that the design must ignore: a second start request and a change of every setting while a frame is still shifting. The stimulus sets a fixed cycle inside a running frame and applies the disturbance there. In one frame it pulses `cmd_go` with a different word. In another it flips the word, count, polarity, phase, order and divider. The scoreboard still expects the bit stream, SCLK count and duration of the original frame. Frame length and divider are varied so that the end-of-frame cycle count is tested for several values of n and the half period.

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx #(
  parameter int DIV_W     = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [8*MAX_BYTES-1:0]       cmd_word,
  input  logic [$clog2(MAX_BYTES)-1:0] cmd_len_m1,
  input  logic                         send_lsb_first,
  input  logic                         clk_pol,
  input  logic                         clk_pha,
  input  logic                         cs_high,
  input  logic [DIV_W-1:0]             half_div,
  input  logic                         cmd_go,
  output logic                         spi_sclk,
  output logic                         spi_mosi,
  output logic                         spi_cs,
  output logic                         cmd_busy,
  output logic                         frame_done
);
  localparam int CMD_W  = 8 * MAX_BYTES;
  localparam int LEN_W  = $clog2(MAX_BYTES);
  localparam int EDGE_W = $clog2(16 * MAX_BYTES + 1);

  logic              busy_q, done_q, sclk_q;
  logic              lsb_q, pol_q, pha_q, csh_q;
  logic [LEN_W-1:0]  len_q;
  logic [DIV_W-1:0]  div_q, cnt_q;
  logic [EDGE_W-1:0] edge_q, edge_nx, last_edge;
  logic [CMD_W-1:0]  sh_q, load_val;
  logic              tick, shift_now, accept;

  assign accept    = cmd_go && !busy_q;
  assign tick      = busy_q && (cnt_q == div_q);
  assign edge_nx   = edge_q + EDGE_W'(1);
  assign last_edge = (EDGE_W'(len_q) + EDGE_W'(1)) << 4;
  assign shift_now = pha_q ? (edge_nx[0] && edge_nx != EDGE_W'(1))
                           : (!edge_nx[0] && edge_nx != last_edge);

  always_comb begin
    if (send_lsb_first)
      load_val = cmd_word;
    else
      load_val = cmd_word << {(LEN_W'(MAX_BYTES - 1) - cmd_len_m1), 3'b000};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      lsb_q  <= 1'b0;
      pol_q  <= 1'b0;
      pha_q  <= 1'b0;
      csh_q  <= 1'b0;
      len_q  <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      edge_q <= '0;
      sh_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        sclk_q <= clk_pol;
        lsb_q  <= send_lsb_first;
        pol_q  <= clk_pol;
        pha_q  <= clk_pha;
        csh_q  <= cs_high;
        len_q  <= cmd_len_m1;
        div_q  <= half_div;
        cnt_q  <= '0;
        edge_q <= '0;
        sh_q   <= load_val;
      end else if (busy_q) begin
        if (!tick) begin
          cnt_q <= cnt_q + DIV_W'(1);
        end else begin
          cnt_q <= '0;
          if (edge_q == last_edge) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            edge_q <= edge_nx;
            sclk_q <= ~sclk_q;
            if (shift_now)
              sh_q <= lsb_q ? (sh_q >> 1) : (sh_q << 1);
          end
        end
      end
    end
  end

  assign spi_sclk   = busy_q ? sclk_q : clk_pol;
  assign spi_mosi   = busy_q && (lsb_q ? sh_q[0] : sh_q[CMD_W-1]);
  assign spi_cs     = busy_q ? csh_q : ~cs_high;
  assign cmd_busy   = busy_q;
  assign frame_done = done_q;

  logic unused_pol;
  assign unused_pol = pol_q;
endmodule

module spi_cmd_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_go,
  input logic cmd_busy,
  input logic frame_done,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs
);
  a_r6_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && $past(cmd_busy)) |-> $stable(spi_cs));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!cmd_busy && $past(cmd_busy)));

  a_r7_fall_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_busy) |-> frame_done);

  a_r8_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !cmd_busy) |=> cmd_busy);

  a_r10_mosi_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && $past(cmd_busy) && $stable(spi_sclk)) |-> $stable(spi_mosi));
endmodule

bind spi_cmd_tx spi_cmd_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_busy(cmd_busy),
  .frame_done(frame_done), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs(spi_cs)
);

// File: tb/spi_cmd_tx_tb.sv
module spi_cmd_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [1:0]  cmd_len_m1 = '0;
  logic send_lsb_first = 1'b0, clk_pol = 1'b1, clk_pha = 1'b0, cs_high = 1'b0;
  logic [7:0] half_div = '0;
  logic cmd_go = 1'b0;
  logic spi_sclk, spi_mosi, spi_cs, cmd_busy, frame_done;

  int total = 0, bad = 0;
  bit exp_q[$];
  bit m_pol, m_pha, m_csh;
  int lead_cnt;
  bit cs_bad;
  logic prev_sclk, prev_busy;

  always #5 clk = ~clk;

  spi_cmd_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_len_m1(cmd_len_m1),
    .send_lsb_first(send_lsb_first), .clk_pol(clk_pol), .clk_pha(clk_pha),
    .cs_high(cs_high), .half_div(half_div), .cmd_go(cmd_go),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs(spi_cs),
    .cmd_busy(cmd_busy), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected bit at every sampling edge of SCLK (R3 R4 R5)
  always @(negedge clk) begin
    if (rst_n && cmd_busy && prev_busy) begin
      if (spi_cs !== m_csh) cs_bad = 1'b1;
      if (spi_sclk !== prev_sclk) begin
        if (spi_sclk != m_pol) lead_cnt++;
        if ((spi_sclk != m_pol) == !m_pha) begin
          if (exp_q.size() == 0) chk(1'b0, "R3/R4 extra bit", int'(spi_mosi), 0);
          else begin
            automatic bit e = exp_q.pop_front();
            chk(spi_mosi === e, "R3/R4/R5 bit", int'(spi_mosi), int'(e));
          end
        end
      end
    end
    prev_sclk = spi_sclk;
    prev_busy = cmd_busy;
  end

  // kind 0: plain, 1: second start mid-frame (R8), 2: change all inputs mid-frame (R9)
  task automatic send(input logic [31:0] w, input int n, input bit lsb, input bit pol,
                      input bit pha, input bit csh, input int div, input int kind);
    int cyc, exp_cyc;
    @(negedge clk);
    cmd_word = w; cmd_len_m1 = 2'(n - 1); send_lsb_first = lsb;
    clk_pol = pol; clk_pha = pha; cs_high = csh; half_div = 8'(div);
    m_pol = pol; m_pha = pha; m_csh = csh; lead_cnt = 0; cs_bad = 1'b0;
    if (!lsb) for (int i = 8*n-1; i >= 0; i--) exp_q.push_back(w[i]);
    else      for (int i = 0; i < 8*n; i++)    exp_q.push_back(w[i]);
    cmd_go = 1'b1;
    cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      cmd_go = 1'b0;
      if (kind == 1 && cyc == 10) begin cmd_go = 1'b1; cmd_word = ~w; end
      if (kind == 2 && cyc == 10) begin
        cmd_word = ~w; cmd_len_m1 = ~cmd_len_m1; send_lsb_first = ~lsb;
        clk_pol = ~pol; clk_pha = ~pha; cs_high = ~csh; half_div = 8'(div + 3);
      end
      if (frame_done) break;
    end
    exp_cyc = (16*n + 1) * (div + 1) + 1;
    chk(cyc == exp_cyc, kind == 1 ? "R8 length" : (kind == 2 ? "R9 length" : "R7 length"), cyc, exp_cyc);
    chk(lead_cnt == 8*n, "R2 sclk cycles", lead_cnt, 8*n);
    chk(exp_q.size() == 0, "R2 bits left", exp_q.size(), 0);
    exp_q.delete();
    chk(!cs_bad, "R6 cs held", int'(cs_bad), 0);
    chk(!cmd_busy && spi_cs == ~cs_high, "R1 idle after frame", {30'd0, cmd_busy, spi_cs}, {31'd0, ~cs_high});
    @(negedge clk);
    chk(!frame_done, "R7 single pulse", int'(frame_done), 0);
    chk(spi_sclk == clk_pol, "R1 sclk idle", int'(spi_sclk), int'(clk_pol));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    prev_sclk = 1'b1; prev_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cmd_busy && !frame_done && spi_cs == 1'b1 && spi_sclk == 1'b1, "R1 reset",
        {cmd_busy, frame_done, spi_cs, spi_sclk}, 4'b0011);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(32'hFFFF_FFA5, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 0);
    send(32'h0000_C3E1, 2, 1'b0, 1'b1, 1'b1, 1'b0, 0, 0);
    send(32'h0012_3456, 3, 1'b1, 1'b0, 1'b1, 1'b1, 2, 0);
    send(32'h1234_5678, 4, 1'b0, 1'b1, 1'b0, 1'b0, 3, 0);  // R3 upper halfword first
    send(32'h8001_7FFE, 4, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0);  // R4
    send(32'h0000_9A5C, 2, 1'b0, 1'b0, 1'b1, 1'b0, 1, 1);  // R8
    send(32'h00AB_CDEF, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1, 2);  // R9
    clk_pol = 1'b1; cs_high = 1'b0;
    send(32'h0000_0081, 1, 1'b1, 1'b1, 1'b1, 1'b1, 4, 0);  // R5 R10
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule